// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block sits between a byte-wide host bus and the internals of a flash memory. The host does not use dedicated program or erase pins. It writes short sequences of unlock patterns followed by a command byte, and the controller decodes each sequence. The address of a write is taken when the write strobe is raised and the data when it is dropped. A complete, correct sequence starts a byte program, a sector erase, a chip erase or a boot-lock enable. Entry and exit sequences for an identification mode are also recognised. A write that breaks a sequence sends the decoder back to idle.

When an operation starts, the controller raises a one-cycle start pulse. The pulse carries the operation kind, the target address and the data. An internal timer then holds a busy flag for a fixed, parameter-set number of clocks. While the timer runs, every write is dropped. Reads return array data in normal mode. In identification mode they return the manufacturer code, the device code and the boot-lock state reported by the external sector guard. A synchronous reset aborts any running operation, leaves identification mode, clears the sequence state and turns the read data drivers off.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A bus write cycle takes its address in the clock where `bus_wr` is first seen high. It takes its data in the clock where `bus_wr` is first seen low again. Address or data changes while the strobe is held do not affect the cycle.
- R2: Byte program is four writes: 0xAA to 0x05555, 0x55 to 0x02AAA, 0xA0 to 0x05555, then the target write. The target write gives a start pulse with `op_kind`=1 and the target's address and data.
- R3: Sector erase is six writes: 0xAA/0x05555, 0x55/0x02AAA, 0x80/0x05555, 0xAA/0x05555, 0x55/0x02AAA, then data 0x30 to any address. It gives `op_kind`=2, with `op_addr` equal to the sixth write's address.
- R4: Chip erase uses the same first five writes with 0x10 to 0x05555 as the sixth. It gives `op_kind`=3.
- R5: Boot-lock enable uses the same first five writes with 0x40 to 0x05555 as the sixth. It gives `op_kind`=4 and does not raise `busy`.
- R6: After a program, sector erase or chip erase start, `busy` is high for exactly PROG_CYC, SECT_CYC or CHIP_CYC clocks respectively. It rises in the same clock as `op_start`.
- R7: Writes made while `busy` is high are ignored. They do not start operations and do not advance any sequence.
- R8: Writes 0xAA/0x05555, 0x55/0x02AAA, 0x90/0x05555 enter identification mode. In that mode a read of address 0 gives MFR_CODE, address 1 gives DEV_CODE, address 2 gives `guard_locked` in bit 0 with the other bits zero, and other addresses give zero. The same pattern with 0xF0 as the third byte exits to normal reads.
- R9: A write whose address or data does not match the expected step returns the decoder to idle. No operation starts from the writes that follow it until a new sequence begins.
- R10: While `rst` is high, `busy`, `op_start` and `bus_rdata_oe` are forced low. Any running operation is cancelled and identification mode is left.
- R11: After reset, reads are in normal mode. A read strobe in one clock gives `bus_rdata_oe` high and `bus_rdata` equal to the array byte at `bus_addr` in the next clock.
- R12: `op_start` is never high in two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | DATA_W | Bus write data |
| bus_wr | input | 1 | Write strobe, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_rdata | output | DATA_W | Registered read data |
| bus_rdata_oe | output | 1 | Read data drive enable (low means high impedance) |
| arr_raddr | output | ADDR_W | Read address sent to the array |
| arr_rdata | input | DATA_W | Array data for `arr_raddr` |
| guard_locked | input | 1 | Boot-lock state from the sector guard |
| op_start | output | 1 | One-cycle operation start pulse |
| op_kind | output | 3 | Operation kind: 1 program, 2 sector erase, 3 chip erase, 4 lock |
| op_addr | output | ADDR_W | Target address of the started operation |
| op_data | output | DATA_W | Data of the started operation |
| busy | output | 1 | Operation timer running |

## Verification
The decoder is driven with the four complete command sequences. It is also driven with sequences broken at the second and at the sixth step, which shows whether a mismatch really resets progress or lets a later write complete a stale sequence. A full program sequence is written during a chip erase and then followed by a lone target write. This separates dropped writes from writes that were queued. Identification reads are made before and after the lock is set and after the exit sequence, and these show which data source feeds the read port. A write whose address and data change while the strobe is held checks the edge on which each is taken.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PROG = 3'd1,
    OP_SECT = 3'd2,
    OP_CHIP = 3'd3,
    OP_LOCK = 3'd4
  } op_kind_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_UNLK2,
    SQ_CMD,
    SQ_PDATA,
    SQ_EUNLK1,
    SQ_EUNLK2,
    SQ_ECMD
  } seq_state_t;
endpackage

// File: rtl/wr_cycle_latch.sv
module wr_cycle_latch #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              cyc_v,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [DATA_W-1:0] cyc_data
);
  logic wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q     <= 1'b0;
      cyc_v    <= 1'b0;
      cyc_addr <= '0;
      cyc_data <= '0;
    end else begin
      wr_q  <= wr;
      cyc_v <= 1'b0;
      if (wr && !wr_q) cyc_addr <= addr;
      if (!wr && wr_q) begin
        cyc_v    <= 1'b1;
        cyc_data <= wdata;
      end
    end
  end

  // R1: one decoded cycle per strobe release
  assert_one_cycle_R1: assert property (@(posedge clk) disable iff (rst)
    cyc_v |=> !cyc_v);
endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int              ADDR_W     = 18,
  parameter int              DATA_W     = 8,
  parameter logic [ADDR_W-1:0] UNLK_A1  = 18'h05555,
  parameter logic [ADDR_W-1:0] UNLK_A2  = 18'h02AAA,
  parameter logic [DATA_W-1:0] UNLK_D1  = 8'hAA,
  parameter logic [DATA_W-1:0] UNLK_D2  = 8'h55,
  parameter logic [DATA_W-1:0] CMD_PROG = 8'hA0,
  parameter logic [DATA_W-1:0] CMD_ERS  = 8'h80,
  parameter logic [DATA_W-1:0] CMD_IDIN = 8'h90,
  parameter logic [DATA_W-1:0] CMD_IDOUT= 8'hF0,
  parameter logic [DATA_W-1:0] CMD_SECT = 8'h30,
  parameter logic [DATA_W-1:0] CMD_CHIP = 8'h10,
  parameter logic [DATA_W-1:0] CMD_LOCK = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_v,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [DATA_W-1:0] cyc_data,
  input  logic              busy,
  output logic              launch,
  output op_kind_t          launch_kind,
  output logic              op_start,
  output op_kind_t          op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              id_mode
);
  seq_state_t state, state_n;
  logic       id_n;
  logic       accept;
  logic       hit1, hit2, at_a1;

  assign accept = cyc_v && !busy;
  assign hit1   = (cyc_addr == UNLK_A1) && (cyc_data == UNLK_D1);
  assign hit2   = (cyc_addr == UNLK_A2) && (cyc_data == UNLK_D2);
  assign at_a1  = (cyc_addr == UNLK_A1);

  always_comb begin
    state_n     = state;
    id_n        = id_mode;
    launch      = 1'b0;
    launch_kind = OP_NONE;
    if (accept) begin
      state_n = SQ_IDLE;
      case (state)
        SQ_IDLE:   if (hit1) state_n = SQ_UNLK2;
        SQ_UNLK2:  if (hit2) state_n = SQ_CMD;
        SQ_CMD: begin
          if (at_a1) begin
            if (cyc_data == CMD_PROG)       state_n = SQ_PDATA;
            else if (cyc_data == CMD_ERS)   state_n = SQ_EUNLK1;
            else if (cyc_data == CMD_IDIN)  id_n = 1'b1;
            else if (cyc_data == CMD_IDOUT) id_n = 1'b0;
          end
        end
        SQ_PDATA: begin
          launch      = 1'b1;
          launch_kind = OP_PROG;
        end
        SQ_EUNLK1: if (hit1) state_n = SQ_EUNLK2;
        SQ_EUNLK2: if (hit2) state_n = SQ_ECMD;
        SQ_ECMD: begin
          if (cyc_data == CMD_SECT) begin
            launch      = 1'b1;
            launch_kind = OP_SECT;
          end else if (at_a1 && cyc_data == CMD_CHIP) begin
            launch      = 1'b1;
            launch_kind = OP_CHIP;
          end else if (at_a1 && cyc_data == CMD_LOCK) begin
            launch      = 1'b1;
            launch_kind = OP_LOCK;
          end
        end
        default: state_n = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      id_mode  <= 1'b0;
      op_start <= 1'b0;
      op_kind  <= OP_NONE;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      state    <= state_n;
      id_mode  <= id_n;
      op_start <= launch;
      if (launch) begin
        op_kind <= launch_kind;
        op_addr <= cyc_addr;
        op_data <= cyc_data;
      end
    end
  end

  // R12: start is a single-cycle pulse
  assert_start_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    op_start |=> !op_start);
  // R6: timed operations raise busy together with the start pulse
  assert_start_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (op_start && op_kind != OP_LOCK) |-> busy);
  // R5: the lock operation never raises busy
  assert_lock_nobusy_R5: assert property (@(posedge clk) disable iff (rst)
    (op_start && op_kind == OP_LOCK) |-> !busy);
endmodule

// File: rtl/op_timer.sv
module op_timer
  import flash_cmd_pkg::*;
#(
  parameter int PROG_CYC = 500,
  parameter int SECT_CYC = 2000,
  parameter int CHIP_CYC = 5000
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     launch,
  input  op_kind_t kind,
  output logic     busy
);
  localparam int MAX_A = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAXC  = (MAX_A > CHIP_CYC) ? MAX_A : CHIP_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] dur;

  always_comb begin
    case (kind)
      OP_PROG: dur = CNT_W'(PROG_CYC);
      OP_SECT: dur = CNT_W'(SECT_CYC);
      OP_CHIP: dur = CNT_W'(CHIP_CYC);
      default: dur = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (launch && !busy && dur != '0) begin
      cnt  <= dur;
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == CNT_W'(1)) busy <= 1'b0;
      cnt <= cnt - 1'b1;
    end
  end

  // R7: the decoder never launches while the timer runs
  assert_no_launch_busy_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !launch);
endmodule

// File: rtl/rd_port.sv
module rd_port #(
  parameter int                ADDR_W   = 18,
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] MFR_CODE = 8'h1F,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'h07
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              id_mode,
  input  logic              locked,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  logic [DATA_W-1:0] id_val;

  always_comb begin
    if (addr == ADDR_W'(0))      id_val = MFR_CODE;
    else if (addr == ADDR_W'(1)) id_val = DEV_CODE;
    else if (addr == ADDR_W'(2)) id_val = {{(DATA_W-1){1'b0}}, locked};
    else                         id_val = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rdata_oe <= 1'b0;
    end else begin
      rdata_oe <= rd;
      if (rd) rdata <= id_mode ? id_val : arr_rdata;
    end
  end

  // R11: data is driven only in the clock after a read strobe
  assert_oe_follows_rd_R11: assert property (@(posedge clk) disable iff (rst)
    rdata_oe |-> $past(rd));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int                ADDR_W   = 18,
  parameter int                DATA_W   = 8,
  parameter int                PROG_CYC = 500,
  parameter int                SECT_CYC = 2000,
  parameter int                CHIP_CYC = 5000,
  parameter logic [DATA_W-1:0] MFR_CODE = 8'h1F,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'h07
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rdata_oe,
  output logic [ADDR_W-1:0] arr_raddr,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic              guard_locked,
  output logic              op_start,
  output logic [2:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              busy
);
  logic              cyc_v;
  logic [ADDR_W-1:0] cyc_addr;
  logic [DATA_W-1:0] cyc_data;
  logic              launch;
  op_kind_t          launch_kind;
  op_kind_t          kind_q;
  logic              id_mode;

  assign arr_raddr = bus_addr;
  assign op_kind   = kind_q;

  wr_cycle_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .cyc_v(cyc_v), .cyc_addr(cyc_addr), .cyc_data(cyc_data)
  );

  cmd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .cyc_v(cyc_v), .cyc_addr(cyc_addr),
    .cyc_data(cyc_data), .busy(busy), .launch(launch),
    .launch_kind(launch_kind), .op_start(op_start), .op_kind(kind_q),
    .op_addr(op_addr), .op_data(op_data), .id_mode(id_mode)
  );

  op_timer #(.PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)) u_timer (
    .clk(clk), .rst(rst), .launch(launch), .kind(launch_kind), .busy(busy)
  );

  rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
            .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rd (
    .clk(clk), .rst(rst), .rd(bus_rd), .addr(bus_addr), .id_mode(id_mode),
    .locked(guard_locked), .arr_rdata(arr_rdata),
    .rdata(bus_rdata), .rdata_oe(bus_rdata_oe)
  );

  // R10: reset leaves the block quiet in the following clock
  assert_reset_quiet_R10: assert property (@(posedge clk)
    rst |=> (!busy && !op_start && !bus_rdata_oe));
endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;
  localparam int DW = 8;
  localparam int P_CYC = 8;
  localparam int S_CYC = 20;
  localparam int C_CYC = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic          bus_rdata_oe;
  logic [AW-1:0] arr_raddr;
  logic [DW-1:0] arr_rdata;
  logic          locked = 1'b0;
  logic          op_start;
  logic [2:0]    op_kind;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic          busy;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign arr_rdata = arr_raddr[7:0] ^ 8'hC3;

  always @(posedge clk) if (op_start && op_kind == 3'd4) locked <= 1'b1;

  flash_cmd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYC(P_CYC),
                   .SECT_CYC(S_CYC), .CHIP_CYC(C_CYC)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rdata_oe(bus_rdata_oe), .arr_raddr(arr_raddr), .arr_rdata(arr_rdata),
    .guard_locked(locked), .op_start(op_start), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data), .busy(busy)
  );

  // {addr, data, start expected, kind expected}
  localparam logic [29:0] VEC [32] = '{
    {18'h05555, 8'hAA, 1'b0, 3'd0}, {18'h02AAA, 8'h55, 1'b0, 3'd0},      // R2
    {18'h05555, 8'hA0, 1'b0, 3'd0}, {18'h01234, 8'h3C, 1'b1, 3'd1},      // R2
    {18'h05555, 8'hAA, 1'b0, 3'd0}, {18'h02AAA, 8'h55, 1'b0, 3'd0},      // R3
    {18'h05555, 8'h80, 1'b0, 3'd0}, {18'h05555, 8'hAA, 1'b0, 3'd0},      // R3
    {18'h02AAA, 8'h55, 1'b0, 3'd0}, {18'h21000, 8'h30, 1'b1, 3'd2},      // R3
    {18'h05555, 8'hAA, 1'b0, 3'd0}, {18'h02AAA, 8'h55, 1'b0, 3'd0},      // R4
    {18'h05555, 8'h80, 1'b0, 3'd0}, {18'h05555, 8'hAA, 1'b0, 3'd0},      // R4
    {18'h02AAA, 8'h55, 1'b0, 3'd0}, {18'h05555, 8'h10, 1'b1, 3'd3},      // R4
    {18'h05555, 8'hAA, 1'b0, 3'd0}, {18'h02AAA, 8'h66, 1'b0, 3'd0},      // R9 bad step 2
    {18'h05555, 8'hA0, 1'b0, 3'd0}, {18'h00100, 8'h11, 1'b0, 3'd0},      // R9 no program
    {18'h05555, 8'hAA, 1'b0, 3'd0}, {18'h02AAA, 8'h55, 1'b0, 3'd0},      // R9
    {18'h05555, 8'h80, 1'b0, 3'd0}, {18'h05555, 8'hAA, 1'b0, 3'd0},      // R9
    {18'h02AAA, 8'h55, 1'b0, 3'd0}, {18'h05555, 8'h77, 1'b0, 3'd0},      // R9 bad step 6
    {18'h05555, 8'hAA, 1'b0, 3'd0}, {18'h02AAA, 8'h55, 1'b0, 3'd0},      // R5
    {18'h05555, 8'h80, 1'b0, 3'd0}, {18'h05555, 8'hAA, 1'b0, 3'd0},      // R5
    {18'h02AAA, 8'h55, 1'b0, 3'd0}, {18'h05555, 8'h40, 1'b1, 3'd4}       // R5
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_addr  = a;
    bus_wr    = 1'b1;
    bus_wdata = 8'h00;
    @(negedge clk);
    bus_wdata = d;
    bus_wr    = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d,
                          output logic oe);
    bus_addr = a;
    bus_rd   = 1'b1;
    @(negedge clk);
    d  = bus_rdata;
    oe = bus_rdata_oe;
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic prefix5();
    bus_write(18'h05555, 8'hAA);
    bus_write(18'h02AAA, 8'h55);
    bus_write(18'h05555, 8'h80);
    bus_write(18'h05555, 8'hAA);
    bus_write(18'h02AAA, 8'h55);
  endtask

  function automatic int count_busy_dummy(input int x);
    return x;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] rv;
    logic          oe;
    int            n;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy == 1'b0 && op_start == 1'b0 && bus_rdata_oe == 1'b0,
        "R10 reset outputs", {busy, op_start, bus_rdata_oe}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R11 normal read after reset
    bus_read(18'h00025, rv, oe);
    chk(oe == 1'b1 && rv == (8'h25 ^ 8'hC3), "R11 array read", rv, 8'h25 ^ 8'hC3);
    chk(bus_rdata_oe == 1'b0, "R11 oe drops", bus_rdata_oe, 0);

    // R8 identification mode, lock clear
    bus_write(18'h05555, 8'hAA);
    bus_write(18'h02AAA, 8'h55);
    bus_write(18'h05555, 8'h90);
    bus_read(18'h00000, rv, oe);
    chk(rv == 8'h1F, "R8 manufacturer code", rv, 8'h1F);
    bus_read(18'h00001, rv, oe);
    chk(rv == 8'h07, "R8 device code", rv, 8'h07);
    bus_read(18'h00002, rv, oe);
    chk(rv == 8'h00, "R8 lock bit clear", rv, 0);
    bus_read(18'h00003, rv, oe);
    chk(rv == 8'h00, "R8 other id address", rv, 0);
    bus_write(18'h05555, 8'hAA);
    bus_write(18'h02AAA, 8'h55);
    bus_write(18'h05555, 8'hF0);
    bus_read(18'h00002, rv, oe);
    chk(rv == (8'h02 ^ 8'hC3), "R8 exit to array", rv, 8'h02 ^ 8'hC3);

    // table walk: R2 R3 R4 R5 R9
    for (int i = 0; i < 32; i++) begin
      bus_write(VEC[i][29:12], VEC[i][11:4]);
      if (VEC[i][3]) begin
        chk(op_start == 1'b1, "R2/R3/R4/R5 start", op_start, 1);
        chk(op_kind == VEC[i][2:0], "R2/R3/R4/R5 kind", op_kind, VEC[i][2:0]);
        chk(op_addr == VEC[i][29:12], "R2/R3 addr", op_addr, VEC[i][29:12]);
      end else begin
        chk(op_start == 1'b0, "R9 no start", op_start, 0);
      end
      wait_idle();
    end
    @(negedge clk);

    // R5 lock state visible in ID mode
    bus_write(18'h05555, 8'hAA);
    bus_write(18'h02AAA, 8'h55);
    bus_write(18'h05555, 8'h90);
    bus_read(18'h00002, rv, oe);
    chk(rv == 8'h01, "R8 lock bit set", rv, 1);
    bus_write(18'h05555, 8'hAA);
    bus_write(18'h02AAA, 8'h55);
    bus_write(18'h05555, 8'hF0);

    // R6 busy durations
    bus_write(18'h05555, 8'hAA);
    bus_write(18'h02AAA, 8'h55);
    bus_write(18'h05555, 8'hA0);
    bus_write(18'h00040, 8'h12);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n == P_CYC, "R6 program busy length", n, P_CYC);
    prefix5();
    bus_write(18'h00800, 8'h30);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n == S_CYC, "R6 sector busy length", n, S_CYC);
    prefix5();
    bus_write(18'h05555, 8'h10);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n == C_CYC, "R6 chip busy length", n, C_CYC);

    // R7 writes during chip erase are dropped
    prefix5();
    bus_write(18'h05555, 8'h10);
    chk(busy == 1'b1, "R7 erase running", busy, 1);
    bus_write(18'h05555, 8'hAA);
    bus_write(18'h02AAA, 8'h55);
    bus_write(18'h05555, 8'hA0);
    bus_write(18'h01234, 8'h3C);
    chk(op_start == 1'b0, "R7 no start while busy", op_start, 0);
    wait_idle();
    @(negedge clk);
    bus_write(18'h01234, 8'h3C);
    chk(op_start == 1'b0, "R7 sequence not advanced", op_start, 0);

    // R1 address at strobe rise, data at strobe fall
    bus_write(18'h05555, 8'hAA);
    bus_write(18'h02AAA, 8'h55);
    bus_write(18'h05555, 8'hA0);
    bus_addr  = 18'h00ABC;
    bus_wdata = 8'h99;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_addr  = 18'h00DEF;
    bus_wdata = 8'h77;
    @(negedge clk);
    bus_wdata = 8'h5A;
    bus_wr    = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(op_start == 1'b1 && op_addr == 18'h00ABC, "R1 address capture", op_addr, 18'h00ABC);
    chk(op_data == 8'h5A, "R1 data capture", op_data, 8'h5A);
    // R12 pulse lasts one clock
    @(negedge clk);
    chk(op_start == 1'b0, "R12 single pulse", op_start, 0);
    wait_idle();

    // R10 reset aborts erase and ID mode
    bus_write(18'h05555, 8'hAA);
    bus_write(18'h02AAA, 8'h55);
    bus_write(18'h05555, 8'h90);
    prefix5();
    bus_write(18'h05555, 8'h10);
    repeat (3) @(negedge clk);
    rst    = 1'b1;
    bus_rd = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0 && bus_rdata_oe == 1'b0, "R10 abort", {busy, bus_rdata_oe}, 0);
    rst    = 1'b0;
    bus_rd = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R10 stays idle", busy, 0);
    bus_read(18'h00000, rv, oe);
    chk(rv == 8'hC3, "R10 ID mode left", rv, 8'hC3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule